// File: doc/BRIEF.md
# Sample-and-Hold Phase Sequencer

This block steps a low-power converter output through a repeating cycle of charging, idling and topping up. After a channel is switched on in a sample-and-hold mode, the sequencer runs one sample phase, then alternates between a hold phase and a refresh phase. It stays in that loop until new data arrives or the channel is switched off. Every phase length is set by a register and counted in periods of a slow low-speed clock. That clock reaches the block as a one-cycle enable pulse, `slow_tick`, in the fast clock domain.

During sample and refresh the analog core is powered. During hold the core and its buffer are off and both output paths are released to high impedance. A pulse on `data_chg` cuts short whatever phase is running and starts a fresh sample phase.

The sample-time register may be rewritten while the channel runs. Each write raises a busy flag for three slow periods, and software waits for the flag to drop before writing again. The hold-time and refresh-time registers can only be written while the channel and its calibration are both off.

Top module: `sh_phase_seq`

## Requirements
- R1: The sequencer is active only when `chan_en` is 1 and `mode_sel[2]` is 1. When it is not active, `phase` is IDLE and `core_on`, `buf_on`, `pin_oe` and `int_oe` are all 0. Phase codes are IDLE=0, SAMPLE=1, HOLD=2, REFRESH=3.
- R2: On the first clock after it becomes active, the sequencer enters SAMPLE. SAMPLE lasts (sample time + 1) `slow_tick` pulses and then moves to HOLD.
- R3: HOLD lasts max(hold time, 1) ticks and then moves to REFRESH. In HOLD, `core_on`, `buf_on`, `pin_oe` and `int_oe` are all 0.
- R4: REFRESH lasts max(refresh time, 1) ticks and then returns to HOLD. The core is powered during REFRESH.
- R5: A `data_chg` pulse while active moves the sequencer to SAMPLE on the next clock from any phase, and the sample count starts over.
- R6: A sample-time write when `busy` is 0 takes effect and sets `busy`. `busy` clears on the third `slow_tick` after that write. Sample-time writes made while `busy` is 1 are discarded.
- R7: `busy` is set on the clock at which the sequencer becomes active.
- R8: Hold-time and refresh-time writes take effect only when both `chan_en` and `cal_en` are 0. Otherwise they are discarded.
- R9: In SAMPLE or REFRESH the outputs follow `mode_sel[1:0]`:
  - 00: buffer on, pin driven.
  - 01: buffer on, pin and internal path driven.
  - 10: buffer off, pin and internal path driven.
  - 11: buffer off, internal path only.
- R10: Clearing `chan_en` returns `phase` to IDLE on the next clock with the core off.
- R11: After reset: sample time is 0, hold time is 1, refresh time is 1, `phase` is IDLE and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable marking each slow-clock period |
| mode_sel | input | 3 | Bit 2 selects sample-and-hold; bits 1:0 select buffer and output paths |
| chan_en | input | 1 | Channel enable |
| cal_en | input | 1 | Calibration enable (locks hold/refresh registers) |
| samp_wr | input | 1 | Sample-time write strobe |
| samp_wdata | input | 10 | Sample-time write value |
| hold_wr | input | 1 | Hold-time write strobe |
| hold_wdata | input | 10 | Hold-time write value |
| refr_wr | input | 1 | Refresh-time write strobe |
| refr_wdata | input | 8 | Refresh-time write value |
| data_chg | input | 1 | Pulse: holding data changed |
| phase | output | 2 | Current phase code |
| core_on | output | 1 | Analog core power enable |
| buf_on | output | 1 | Output buffer power enable |
| pin_oe | output | 1 | Drive enable for the external pin |
| int_oe | output | 1 | Drive enable for the on-chip path |
| busy | output | 1 | Sample-time update in progress |

## Verification
A phase counter that is wrong shows up as a phase lasting the wrong number of slow ticks. The error is visible on `phase` at the first tick where the length differs from the programmed value. A wrong next-state shows within one clock as a forbidden transition, such as SAMPLE straight to REFRESH or staying out of IDLE after disable. If the sequencer reaches HOLD with the enables still up, `core_on`, `pin_oe` or `int_oe` is visibly high during that same cycle. A defective busy counter moves the drop of `busy` off the third tick. A write that leaks through while a register is locked changes a later measured phase length.

// File: rtl/sh_pkg.sv
package sh_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_HOLD    = 2'd2,
    PH_REFRESH = 2'd3
  } sh_phase_e;
endpackage

// File: rtl/sh_time_regs.sv
module sh_time_regs #(
  parameter int SAMP_W     = 10,
  parameter int HOLD_W     = 10,
  parameter int REFR_W     = 8,
  parameter int BUSY_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              active,
  input  logic              chan_en,
  input  logic              cal_en,
  input  logic              samp_wr,
  input  logic [SAMP_W-1:0] samp_wdata,
  input  logic              hold_wr,
  input  logic [HOLD_W-1:0] hold_wdata,
  input  logic              refr_wr,
  input  logic [REFR_W-1:0] refr_wdata,
  output logic [SAMP_W-1:0] samp_time,
  output logic [HOLD_W-1:0] hold_time,
  output logic [REFR_W-1:0] refr_time,
  output logic              busy
);
  localparam int BC_W = $clog2(BUSY_TICKS + 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BUSY_TICKS - 1);

  logic            act_q;
  logic [BC_W-1:0] bcnt;
  logic            samp_take;
  logic            start_busy;
  logic            cfg_open;

  assign samp_take  = samp_wr && !busy;
  assign start_busy = active && !act_q;
  assign cfg_open   = !chan_en && !cal_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_time <= '0;
      hold_time <= HOLD_W'(1);
      refr_time <= REFR_W'(1);
    end else begin
      if (samp_take) samp_time <= samp_wdata;
      if (hold_wr && cfg_open) hold_time <= hold_wdata;
      if (refr_wr && cfg_open) refr_time <= refr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      busy  <= 1'b0;
      bcnt  <= '0;
    end else begin
      act_q <= active;
      if (samp_take || start_busy) begin
        busy <= 1'b1;
        bcnt <= '0;
      end else if (busy && slow_tick) begin
        if (bcnt == BC_LAST) begin
          busy <= 1'b0;
          bcnt <= '0;
        end else begin
          bcnt <= bcnt + BC_W'(1);
        end
      end
    end
  end

  p_busy_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_wr && !busy) |=> busy);
  p_samp_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (samp_time == $past(samp_time)));
  p_busy_on_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !act_q) |=> busy);
  p_hold_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en || cal_en) |=> (hold_time == $past(hold_time) && refr_time == $past(refr_time)));
endmodule

// File: rtl/sh_phase_fsm.sv
module sh_phase_fsm
  import sh_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int HOLD_W = 10,
  parameter int REFR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              active,
  input  logic              data_chg,
  input  logic [SAMP_W-1:0] samp_time,
  input  logic [HOLD_W-1:0] hold_time,
  input  logic [REFR_W-1:0] refr_time,
  output sh_phase_e         phase
);
  localparam int W1    = (SAMP_W > HOLD_W) ? SAMP_W : HOLD_W;
  localparam int CNT_W = (W1 > REFR_W) ? W1 : REFR_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_nx;
  logic             last_tick;
  sh_phase_e        after_last;

  assign cnt_nx = {1'b0, cnt} + (CNT_W+1)'(1);

  always_comb begin
    last_tick  = 1'b0;
    after_last = PH_HOLD;
    unique case (phase)
      PH_SAMPLE:  begin
        last_tick  = (cnt == CNT_W'(samp_time));
        after_last = PH_HOLD;
      end
      PH_HOLD:    begin
        last_tick  = (cnt_nx >= (CNT_W+1)'(hold_time));
        after_last = PH_REFRESH;
      end
      PH_REFRESH: begin
        last_tick  = (cnt_nx >= (CNT_W+1)'(refr_time));
        after_last = PH_HOLD;
      end
      default:    begin
        last_tick  = 1'b0;
        after_last = PH_SAMPLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (!active) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (data_chg || phase == PH_IDLE) begin
      phase <= PH_SAMPLE;
      cnt   <= '0;
    end else if (slow_tick) begin
      if (last_tick) begin
        phase <= after_last;
        cnt   <= '0;
      end else begin
        cnt <= cnt_nx[CNT_W-1:0];
      end
    end
  end

  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (phase == PH_IDLE));
  p_sample_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAMPLE) |=> (phase != PH_REFRESH));
  p_refresh_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REFRESH && active && !data_chg) |=> (phase == PH_REFRESH || phase == PH_HOLD));
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && data_chg) |=> (phase == PH_SAMPLE));
endmodule

// File: rtl/sh_out_decode.sv
module sh_out_decode
  import sh_pkg::*;
(
  input  sh_phase_e  phase,
  input  logic [1:0] path_sel,
  output logic       core_on,
  output logic       buf_on,
  output logic       pin_oe,
  output logic       int_oe
);
  logic powered;

  assign powered = (phase == PH_SAMPLE) || (phase == PH_REFRESH);
  assign core_on = powered;
  assign buf_on  = powered && !path_sel[1];
  assign pin_oe  = powered && (path_sel != 2'b11);
  assign int_oe  = powered && (path_sel != 2'b00);
endmodule

// File: rtl/sh_phase_seq.sv
module sh_phase_seq
  import sh_pkg::*;
#(
  parameter int SAMP_W     = 10,
  parameter int HOLD_W     = 10,
  parameter int REFR_W     = 8,
  parameter int BUSY_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [2:0]        mode_sel,
  input  logic              chan_en,
  input  logic              cal_en,
  input  logic              samp_wr,
  input  logic [SAMP_W-1:0] samp_wdata,
  input  logic              hold_wr,
  input  logic [HOLD_W-1:0] hold_wdata,
  input  logic              refr_wr,
  input  logic [REFR_W-1:0] refr_wdata,
  input  logic              data_chg,
  output logic [1:0]        phase,
  output logic              core_on,
  output logic              buf_on,
  output logic              pin_oe,
  output logic              int_oe,
  output logic              busy
);
  logic              active;
  logic [SAMP_W-1:0] samp_time;
  logic [HOLD_W-1:0] hold_time;
  logic [REFR_W-1:0] refr_time;
  sh_phase_e         ph;

  assign active = chan_en && mode_sel[2];
  assign phase  = ph;

  sh_time_regs #(
    .SAMP_W(SAMP_W), .HOLD_W(HOLD_W), .REFR_W(REFR_W), .BUSY_TICKS(BUSY_TICKS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .active(active),
    .chan_en(chan_en), .cal_en(cal_en),
    .samp_wr(samp_wr), .samp_wdata(samp_wdata),
    .hold_wr(hold_wr), .hold_wdata(hold_wdata),
    .refr_wr(refr_wr), .refr_wdata(refr_wdata),
    .samp_time(samp_time), .hold_time(hold_time), .refr_time(refr_time),
    .busy(busy)
  );

  sh_phase_fsm #(
    .SAMP_W(SAMP_W), .HOLD_W(HOLD_W), .REFR_W(REFR_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .active(active),
    .data_chg(data_chg), .samp_time(samp_time), .hold_time(hold_time),
    .refr_time(refr_time), .phase(ph)
  );

  sh_out_decode u_dec (
    .phase(ph), .path_sel(mode_sel[1:0]),
    .core_on(core_on), .buf_on(buf_on), .pin_oe(pin_oe), .int_oe(int_oe)
  );

  p_hold_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HOLD) |-> (!core_on && !buf_on && !pin_oe && !int_oe));
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!core_on && !pin_oe && !int_oe));
endmodule

// File: tb/tb_sh_phase_seq.sv
module tb_sh_phase_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic [2:0] mode_sel = 3'b100;
  logic       chan_en = 1'b0;
  logic       cal_en = 1'b0;
  logic       samp_wr = 1'b0;
  logic [9:0] samp_wdata = '0;
  logic       hold_wr = 1'b0;
  logic [9:0] hold_wdata = '0;
  logic       refr_wr = 1'b0;
  logic [7:0] refr_wdata = '0;
  logic       data_chg = 1'b0;
  logic [1:0] phase;
  logic       core_on, buf_on, pin_oe, int_oe, busy;

  int total = 0;
  int fails = 0;

  localparam int NV = 4;
  localparam logic [9:0] V_SAMP [NV] = '{10'd0, 10'd2, 10'd5, 10'd1};
  localparam logic [9:0] V_HOLD [NV] = '{10'd1, 10'd3, 10'd0, 10'd2};
  localparam logic [7:0] V_REFR [NV] = '{8'd1,  8'd2,  8'd4,  8'd0};
  localparam int E_SAMP [NV] = '{1, 3, 6, 2};
  localparam int E_HOLD [NV] = '{1, 3, 1, 2};
  localparam int E_REFR [NV] = '{1, 2, 4, 1};

  localparam int IDLE = 0, SAMP = 1, HOLD = 2, REFR = 3;

  sh_phase_seq dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .mode_sel(mode_sel),
    .chan_en(chan_en), .cal_en(cal_en), .samp_wr(samp_wr), .samp_wdata(samp_wdata),
    .hold_wr(hold_wr), .hold_wdata(hold_wdata), .refr_wr(refr_wr), .refr_wdata(refr_wdata),
    .data_chg(data_chg), .phase(phase), .core_on(core_on), .buf_on(buf_on),
    .pin_oe(pin_oe), .int_oe(int_oe), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic measure(input int ph, output int n);
    n = 0;
    while (phase == ph && n < 3000) begin
      tick();
      n++;
    end
  endtask

  task automatic wr_samp(input int v);
    samp_wr = 1'b1; samp_wdata = 10'(v);
    @(negedge clk);
    samp_wr = 1'b0;
  endtask

  task automatic wr_hold(input int v);
    hold_wr = 1'b1; hold_wdata = 10'(v);
    @(negedge clk);
    hold_wr = 1'b0;
  endtask

  task automatic wr_refr(input int v);
    refr_wr = 1'b1; refr_wdata = 8'(v);
    @(negedge clk);
    refr_wr = 1'b0;
  endtask

  task automatic pulse_chg();
    data_chg = 1'b1;
    @(negedge clk);
    data_chg = 1'b0;
  endtask

  task automatic settle_busy();
    for (int k = 0; k < 6 && busy; k++) tick();
  endtask

  task automatic outs(input string req, input int c, input int b, input int p, input int i);
    chk({req, " core_on"}, int'(core_on), c);
    chk({req, " buf_on"}, int'(buf_on), b);
    chk({req, " pin_oe"}, int'(pin_oe), p);
    chk({req, " int_oe"}, int'(int_oe), i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 phase", int'(phase), IDLE);
    chk("R11 busy", int'(busy), 0);
    outs("R11", 0, 0, 0, 0);

    // R11: reset timing values, hold 1 / refresh 1 / sample 0
    chan_en = 1'b1;
    @(negedge clk);
    measure(SAMP, n); chk("R11 sample len", n, 1);
    measure(HOLD, n); chk("R11 hold len", n, 1);
    measure(REFR, n); chk("R11 refresh len", n, 1);
    chan_en = 1'b0;
    @(negedge clk);

    // Table walk: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      chan_en = 1'b0;
      @(negedge clk);
      settle_busy();
      wr_hold(int'(V_HOLD[v]));
      wr_refr(int'(V_REFR[v]));
      wr_samp(int'(V_SAMP[v]));
      settle_busy();
      chan_en = 1'b1;
      @(negedge clk);
      chk("R2 enters sample", int'(phase), SAMP);
      measure(SAMP, n); chk("R2 sample len", n, E_SAMP[v]);
      chk("R2 then hold", int'(phase), HOLD);
      outs("R3 hold", 0, 0, 0, 0);
      measure(HOLD, n); chk("R3 hold len", n, E_HOLD[v]);
      chk("R3 then refresh", int'(phase), REFR);
      chk("R4 core in refresh", int'(core_on), 1);
      measure(REFR, n); chk("R4 refresh len", n, E_REFR[v]);
      chk("R4 back to hold", int'(phase), HOLD);
    end

    // R10 disable
    chan_en = 1'b0;
    @(negedge clk);
    chk("R10 idle", int'(phase), IDLE);
    outs("R10", 0, 0, 0, 0);

    // R1 normal mode: no sequencing, no busy
    settle_busy();
    mode_sel = 3'b001;
    chan_en = 1'b1;
    @(negedge clk);
    tick();
    chk("R1 normal mode phase", int'(phase), IDLE);
    chk("R1 normal mode busy", int'(busy), 0);
    outs("R1", 0, 0, 0, 0);
    chan_en = 1'b0;
    mode_sel = 3'b100;
    @(negedge clk);

    // R6 busy timing and discarded write
    wr_samp(4);
    chk("R6 busy set", int'(busy), 1);
    wr_samp(9);
    tick(); tick();
    chk("R6 busy after 2 ticks", int'(busy), 1);
    tick();
    chk("R6 busy after 3 ticks", int'(busy), 0);
    // R8 locked writes: program hold 3 / refresh 2 first
    wr_hold(3);
    wr_refr(2);
    // R7 busy on enable
    chan_en = 1'b1;
    @(negedge clk);
    chk("R7 busy on enable", int'(busy), 1);
    measure(SAMP, n); chk("R6 ignored write, sample len", n, 5);
    wr_hold(7);
    wr_refr(6);
    chan_en = 1'b0; cal_en = 1'b1;
    @(negedge clk);
    wr_hold(8);
    cal_en = 1'b0; chan_en = 1'b1;
    @(negedge clk);
    settle_busy();
    // R6 live update while running
    wr_samp(2);
    chk("R6 live write busy", int'(busy), 1);
    // R5 restart from hold or refresh
    pulse_chg();
    chk("R5 restart", int'(phase), SAMP);
    measure(SAMP, n); chk("R6 live sample len", n, 3);
    measure(HOLD, n); chk("R8 hold unchanged", n, 3);
    measure(REFR, n); chk("R8 refresh unchanged", n, 2);
    // R5 mid-sample restart restarts count
    pulse_chg();
    tick(); tick();
    pulse_chg();
    chk("R5 mid-sample restart", int'(phase), SAMP);
    measure(SAMP, n); chk("R5 full sample after restart", n, 3);

    // R9 path decode in sample
    pulse_chg();
    mode_sel = 3'b100; #1; outs("R9 m100", 1, 1, 1, 0);
    mode_sel = 3'b101; #1; outs("R9 m101", 1, 1, 1, 1);
    mode_sel = 3'b110; #1; outs("R9 m110", 1, 0, 1, 1);
    mode_sel = 3'b111; #1; outs("R9 m111", 1, 0, 0, 1);
    mode_sel = 3'b100;

    // R10 disable mid-phase
    chan_en = 1'b0;
    @(negedge clk);
    chk("R10 idle after disable", int'(phase), IDLE);
    chk("R10 core off", int'(core_on), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule